// File: doc/BRIEF.md
# Full-Period Pseudorandom 4-Bit Sequence Counter

This block is a 4-bit shift-register sequence generator that walks through every 4-bit value in a fixed, scrambled order. It shifts left once per enabled clock, and the bit shifted in is an XOR of the two most significant state bits. A correction term then splices the all-zero value into the loop, so one period is 16 steps long rather than 15.

Its port list has the same shape as a plain 4-bit up-counter: a clock, an active-low reset, a step enable and the 4-bit state. A bench written for that counter can therefore drive this block unchanged and compare against a different expected order. Reset is sampled on the clock edge and loads 0000. That is a legal member of the loop, so no seed value is needed.

Top module: `lfsrz_counter`

## Requirements
- R1: When `rst_ni` is low at a rising clock edge, `state_o` is 0000 after that edge, whatever `step_en_i` is.
- R2: When `rst_ni` is high and `step_en_i` is low at a rising edge, `state_o` keeps its value.
- R3: When stepping from any state other than 0000 and 1000, the next state is the old state shifted left by one bit. The new bit 0 equals old bit 3 XOR old bit 2, which is the polynomial x^4 + x^3 + 1.
- R4: When stepping from 1000, the next state is 0000.
- R5: When stepping from 0000, the next state is 0001.
- R6: Starting from 0000 with the enable held high, the states come in this order: 0000, 0001, 0010, 0100, 1001, 0011, 0110, 1101, 1010, 0101, 1011, 0111, 1111, 1110, 1100, 1000. The state after 1000 is 0000 again.
- R7: Over any 16 consecutive enabled steps, each of the 16 values appears exactly once, and the state then equals the starting value.
- R8: A reset applied at any point in the sequence restarts it: the state is 0000, and the next enabled step gives 0001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Active-low reset, sampled on the clock edge |
| step_en_i | input | 1 | Advance the sequence by one step on this edge when high |
| state_o | output | 4 | Current sequence value |

## Verification
Every state value is visible directly on `state_o`, so a wrong next-state decision shows at the ports one clock edge after the step that caused it. A broken zero splice shows up in one of two ways: 1000 fails to reach 0000, or 0000 locks up. Either way, the 16-step walk breaks within one period, so the uniqueness and order checks catch it. A wrong hold or reset decision is likewise visible on the edge right after the enable or reset is applied.

// File: rtl/lfsrz_pkg.sv
package lfsrz_pkg;

    localparam int unsigned LFSR_W = 4;

    // What the state register does on the next edge
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_SHIFT = 2'd1,
        ACT_CLEAR = 2'd2
    } lfsr_act_e;

endpackage

// File: rtl/lfsrz_feedback.sv
module lfsrz_feedback #(
    parameter int unsigned WIDTH = lfsrz_pkg::LFSR_W
) (
    input  logic [WIDTH-1:0] cur_i,
    output logic             fb_o
);
    localparam int unsigned TAP_A = WIDTH - 1;
    localparam int unsigned TAP_B = WIDTH - 2;

    logic base_fb;
    logic low_clear;

    always_comb begin
        base_fb   = cur_i[TAP_A] ^ cur_i[TAP_B];
        // All bits below the top are clear: current state is 0..0 or 10..0
        low_clear = (cur_i[WIDTH-2:0] == '0);
        fb_o      = base_fb ^ low_clear;
    end
endmodule

// File: rtl/lfsrz_ctrl.sv
module lfsrz_ctrl (
    input  logic                  rst_ni,
    input  logic                  step_en_i,
    output lfsrz_pkg::lfsr_act_e  act_o
);
    import lfsrz_pkg::*;

    always_comb begin
        if (!rst_ni)        act_o = ACT_CLEAR;
        else if (step_en_i) act_o = ACT_SHIFT;
        else                act_o = ACT_HOLD;
    end
endmodule

// File: rtl/lfsrz_state_reg.sv
module lfsrz_state_reg #(
    parameter int unsigned WIDTH = lfsrz_pkg::LFSR_W
) (
    input  logic                  clk_i,
    input  lfsrz_pkg::lfsr_act_e  act_i,
    input  logic                  fb_i,
    output logic [WIDTH-1:0]      q_o
);
    import lfsrz_pkg::*;

    logic [WIDTH-1:0] q_r;

    always_ff @(posedge clk_i) begin
        case (act_i)
            ACT_CLEAR: q_r <= '0;
            ACT_SHIFT: q_r <= {q_r[WIDTH-2:0], fb_i};
            default:   q_r <= q_r;
        endcase
    end

    assign q_o = q_r;

    // R2: a hold decision leaves the register untouched
    assert_hold_R2: assert property (@(posedge clk_i)
        (act_i == ACT_HOLD) |=> $stable(q_r))
        else $error("assert_hold_R2");

    // R1: a clear decision always lands on zero
    assert_clear_R1: assert property (@(posedge clk_i)
        (act_i == ACT_CLEAR) |=> (q_r == '0))
        else $error("assert_clear_R1");
endmodule

// File: rtl/lfsrz_counter.sv
module lfsrz_counter #(
    parameter int unsigned WIDTH = lfsrz_pkg::LFSR_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             step_en_i,
    output logic [WIDTH-1:0] state_o
);
    import lfsrz_pkg::*;

    localparam logic [WIDTH-1:0] TOP_ONLY = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [WIDTH-1:0] LOW_ONE  = {{(WIDTH-1){1'b0}}, 1'b1};

    lfsr_act_e        act;
    logic             fb;
    logic [WIDTH-1:0] q;

    lfsrz_ctrl u_ctrl (
        .rst_ni    (rst_ni),
        .step_en_i (step_en_i),
        .act_o     (act)
    );

    lfsrz_feedback #(.WIDTH(WIDTH)) u_fb (
        .cur_i (q),
        .fb_o  (fb)
    );

    lfsrz_state_reg #(.WIDTH(WIDTH)) u_reg (
        .clk_i (clk_i),
        .act_i (act),
        .fb_i  (fb),
        .q_o   (q)
    );

    assign state_o = q;

    // R1 / R8: reset at the port forces zero on the next edge
    assert_reset_zero_R1: assert property (@(posedge clk_i)
        !rst_ni |=> (state_o == '0))
        else $error("assert_reset_zero_R1");

    // R4: the top-only state wraps to zero
    assert_wrap_to_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_en_i && state_o == TOP_ONLY) |=> (state_o == '0))
        else $error("assert_wrap_to_zero_R4");

    // R5: zero is left towards 0..01
    assert_leave_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_en_i && state_o == '0) |=> (state_o == LOW_ONE))
        else $error("assert_leave_zero_R5");

    // R3: ordinary steps are a left shift
    assert_shift_left_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_en_i && state_o != '0 && state_o != TOP_ONLY)
            |=> (state_o[WIDTH-1:1] == $past(state_o[WIDTH-2:0])) && (state_o != '0))
        else $error("assert_shift_left_R3");
endmodule

// File: tb/lfsrz_counter_tb.sv
module lfsrz_counter_tb;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       step_en_i = 1'b0;
    logic [3:0] state_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Expected R6 order starting at 0000
    logic [3:0] exp_seq [16] = '{4'h0, 4'h1, 4'h2, 4'h4, 4'h9, 4'h3, 4'h6, 4'hD,
                                 4'hA, 4'h5, 4'hB, 4'h7, 4'hF, 4'hE, 4'hC, 4'h8};

    always #10 clk_i = ~clk_i;   // 50 MHz

    lfsrz_counter u_dut (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .step_en_i (step_en_i),
        .state_o   (state_o)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: state_o=%b expected=%b", req, act, exp);
        end
    endtask

    // Apply inputs, take one edge, sample 5 ns later
    task automatic cyc(input logic rst_val, input logic en);
        rst_ni    = rst_val;
        step_en_i = en;
        @(posedge clk_i);
        #5;
    endtask

    function automatic logic [3:0] rule_next(input logic [3:0] s);
        if (s == 4'b1000) return 4'b0000;
        if (s == 4'b0000) return 4'b0001;
        return {s[2:0], s[3] ^ s[2]};
    endfunction

    task automatic t_reset();
        cyc(1'b0, 1'b1);
        chk("R1 reset with enable high", state_o, 4'h0);
        cyc(1'b0, 1'b0);
        chk("R1 reset with enable low", state_o, 4'h0);
    endtask

    task automatic t_order();
        logic [3:0] prev;
        cyc(1'b0, 1'b0);
        chk("R6 start", state_o, exp_seq[0]);
        for (int i = 1; i <= 16; i++) begin
            prev = state_o;
            cyc(1'b1, 1'b1);
            chk("R6 order", state_o, exp_seq[i % 16]);
            if (prev == 4'b1000)      chk("R4 wrap", state_o, 4'b0000);
            else if (prev == 4'b0000) chk("R5 leave zero", state_o, 4'b0001);
            else                      chk("R3 shift rule", state_o, rule_next(prev));
        end
    endtask

    task automatic t_unique();
        logic [15:0] seen;
        logic [3:0]  start;
        cyc(1'b1, 1'b1);
        cyc(1'b1, 1'b1);
        cyc(1'b1, 1'b1);
        start = state_o;
        seen  = '0;
        for (int i = 0; i < 16; i++) begin
            n_checks++;
            if (seen[state_o]) begin
                n_fail++;
                $display("FAIL R7: value %b repeated at step %0d (expected unique)", state_o, i);
            end
            seen[state_o] = 1'b1;
            cyc(1'b1, 1'b1);
        end
        chk("R7 all 16 seen", {3'b000, &seen}, 4'b0001);
        chk("R7 period returns to start", state_o, start);
    endtask

    task automatic t_hold();
        logic [3:0] kept;
        for (int k = 0; k < 4; k++) begin
            for (int s = 0; s < k + 2; s++) cyc(1'b1, 1'b1);
            kept = state_o;
            for (int h = 0; h < 5; h++) begin
                cyc(1'b1, 1'b0);
                chk("R2 hold", state_o, kept);
            end
            cyc(1'b1, 1'b1);
            chk("R2 resume after hold", state_o, rule_next(kept));
        end
        // Hold exactly at zero and at 1000
        cyc(1'b0, 1'b0);
        cyc(1'b1, 1'b0);
        chk("R2 hold at zero", state_o, 4'h0);
        for (int s = 0; s < 15; s++) cyc(1'b1, 1'b1);
        chk("R6 reach 1000", state_o, 4'h8);
        cyc(1'b1, 1'b0);
        chk("R2 hold at 1000", state_o, 4'h8);
    endtask

    task automatic t_reset_mid();
        for (int p = 1; p < 16; p += 4) begin
            cyc(1'b0, 1'b0);
            for (int s = 0; s < p; s++) cyc(1'b1, 1'b1);
            chk("R8 position before reset", state_o, exp_seq[p]);
            cyc(1'b0, 1'b1);
            chk("R8 reset mid-sequence", state_o, 4'h0);
            cyc(1'b1, 1'b1);
            chk("R8 restart step", state_o, 4'h1);
        end
    endtask

    initial begin
        #5;
        t_reset();
        t_order();
        t_unique();
        t_hold();
        t_reset_mid();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish (expected completion)");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule